// File: doc/BRIEF.md
# Processor Interrupt Presenter

This block holds the interrupt presentation state of a single processor. It keeps five pieces of state: the processor's current priority, the priority of the pending inter-processor request, the number of the pending source, the priority of that pending source, and a flag that records a refused delivery. A lower number is a more favoured priority. Source controllers offer interrupts through the delivery port. The processor works on the state through one operation port with five operations: accept, poll, set priority, end-of-interrupt and inter-processor request write.

Each operation is a named transition of the presentation state. ACCEPT hands over the pending source. POLL only reads. SET_CPPR raises or lowers the processor priority. EOI lowers the priority and reports the finished source. SET_MFRR posts or withdraws an inter-processor request. The inter-processor request shares the single pending slot with external sources under a reserved source number. When a source is pushed out of the slot, it is handed back as a reject so that it can be delivered again. A refused delivery arms the flag. The flag turns into a one-cycle resend request when the processor priority drops or the inter-processor request priority is made less favoured.

If an operation and a delivery arrive in the same cycle, the operation is applied first and the delivery is judged against the result. Every output except the interrupt line is registered and appears one cycle after its inputs.

Top module: `irq_presenter`

## Requirements
- R1: `irq_out` is high exactly when the pending source number is nonzero and the pending priority is numerically below the processor priority.
- R2: A delivery succeeds (`dlv_ok`=1) only when its priority is strictly below the processor priority, the request priority and the pending priority. On success the new source and priority take the pending slot. The displaced source number is reported on the delivery reject outputs.
- R3: A refused delivery (`dlv_done`=1, `dlv_ok`=0) leaves the pending slot unchanged and arms the resend flag. The flag is then seen as `resend_req` at the next resend opportunity.
- R4: ACCEPT (op code 0) returns {processor priority, pending source}. If the source is nonzero, the processor priority then takes the pending priority, the pending priority becomes all ones (0xFF at default width) and the source is cleared.
- R5: SET_CPPR (op code 2, new value in the low priority bits) with a smaller value sets the priority. If the new value is at or below the pending priority, it also rejects the pending source and empties the slot. An equal value changes nothing.
- R6: Lowering the priority, either by SET_CPPR with a larger value or by EOI (op code 3, new priority in the top priority bits of the word), loads the new priority. If the request priority is below the new priority and at or below the pending priority, the inter-processor request becomes pending at the request priority. `resend_req` pulses if the flag was armed, and the flag clears.
- R7: SET_MFRR (op code 4) loads the request priority. If the value is below the processor priority and at or below the pending priority, it rejects the pending source and makes the inter-processor request pending. If the value is above the old request priority, `resend_req` pulses when the flag was armed, and the flag clears.
- R8: A rejected source number of zero or of the reserved number (`IPI_ID`, default 2) is never reported as a reject. EOI takes the source number from the low source bits of the word and forwards it on `eoi_valid`/`eoi_src`, except for the reserved number.
- R9: POLL (op code 1) returns the same word as ACCEPT together with the request priority on `ret_mfrr`, and changes no state.
- R10: After reset the processor priority and source are 0, and the request and pending priorities are all ones. Every delivery is refused.
- R11: Within one cycle the operation is applied before the delivery. Op codes 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery attempt |
| dlv_src | input | SRC_W | Source number offered |
| dlv_pri | input | PRI_W | Priority offered |
| op_valid | input | 1 | Processor operation valid |
| op_code | input | 3 | 0 accept, 1 poll, 2 set priority, 3 EOI, 4 request write |
| op_data | input | PRI_W+SRC_W | Operand word |
| irq_out | output | 1 | Interrupt line to the processor |
| ret_valid | output | 1 | Accept/poll result valid |
| ret_word | output | PRI_W+SRC_W | {processor priority, pending source} |
| ret_mfrr | output | PRI_W | Request priority at the accept/poll |
| op_rej_valid | output | 1 | Operation displaced a source |
| op_rej_src | output | SRC_W | Source displaced by the operation |
| dlv_done | output | 1 | Delivery result valid |
| dlv_ok | output | 1 | Delivery taken |
| dlv_rej_valid | output | 1 | Delivery displaced a source |
| dlv_rej_src | output | SRC_W | Source displaced by the delivery |
| eoi_valid | output | 1 | End-of-interrupt forwarded to the source side |
| eoi_src | output | SRC_W | Source being ended |
| resend_req | output | 1 | Request for a resend scan |

## Verification
The bench builds the block with 4-bit priorities, 8-bit source numbers and reserved number 2. With only sixteen priority levels, a long pseudo-random stream of mixed operations and deliveries reaches every ordering of processor, request and pending priority many times. That includes the ties that decide rejects and inter-processor request folding. A bench-side model computes every registered output each cycle. Directed steps pin down the reset state, the equal-priority write and the end-of-interrupt of the reserved number.

// File: rtl/pres_pkg.sv
package pres_pkg;
    typedef enum logic [2:0] {
        OP_ACCEPT   = 3'd0,
        OP_POLL     = 3'd1,
        OP_SET_CPPR = 3'd2,
        OP_EOI      = 3'd3,
        OP_SET_MFRR = 3'd4
    } op_e;
endpackage

// File: rtl/pres_op_unit.sv
module pres_op_unit
    import pres_pkg::*;
#(
    parameter int PRI_W  = 8,
    parameter int SRC_W  = 24,
    parameter int IPI_ID = 2,
    localparam int WORD_W = PRI_W + SRC_W
) (
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    input  logic [PRI_W-1:0]  cur_cppr,
    input  logic [PRI_W-1:0]  cur_mfrr,
    input  logic [PRI_W-1:0]  cur_ppri,
    input  logic [SRC_W-1:0]  cur_xisr,
    input  logic              cur_nr,
    output logic [PRI_W-1:0]  nx_cppr,
    output logic [PRI_W-1:0]  nx_mfrr,
    output logic [PRI_W-1:0]  nx_ppri,
    output logic [SRC_W-1:0]  nx_xisr,
    output logic              nx_nr,
    output logic              ret_valid,
    output logic [WORD_W-1:0] ret_word,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend
);
    localparam logic [PRI_W-1:0] ONES = {PRI_W{1'b1}};
    localparam logic [SRC_W-1:0] IPI  = SRC_W'(IPI_ID);

    logic [PRI_W-1:0] low_val;
    logic [PRI_W-1:0] down_val;
    logic             down_en;
    logic [SRC_W-1:0] rej_raw;

    assign low_val = op_data[PRI_W-1:0];
    assign eoi_src = op_data[SRC_W-1:0];

    always_comb begin
        nx_cppr   = cur_cppr;
        nx_mfrr   = cur_mfrr;
        nx_ppri   = cur_ppri;
        nx_xisr   = cur_xisr;
        nx_nr     = cur_nr;
        ret_valid = 1'b0;
        ret_word  = {cur_cppr, cur_xisr};
        rej_raw   = '0;
        eoi_valid = 1'b0;
        resend    = 1'b0;
        down_en   = 1'b0;
        down_val  = low_val;
        if (op_valid) begin
            unique case (op_e'(op_code))
                OP_ACCEPT: begin
                    ret_valid = 1'b1;
                    if (cur_xisr != '0) begin
                        nx_cppr = cur_ppri;
                        nx_ppri = ONES;
                        nx_xisr = '0;
                    end
                end
                OP_POLL: ret_valid = 1'b1;
                OP_SET_CPPR: begin
                    if (low_val > cur_cppr) begin
                        down_en = 1'b1;
                    end else if (low_val < cur_cppr) begin
                        nx_cppr = low_val;
                        if (low_val <= cur_ppri) begin
                            rej_raw = cur_xisr;
                            nx_xisr = '0;
                            nx_ppri = ONES;
                        end
                    end
                end
                OP_EOI: begin
                    down_en   = 1'b1;
                    down_val  = op_data[WORD_W-1 -: PRI_W];
                    eoi_valid = (eoi_src != IPI);
                end
                OP_SET_MFRR: begin
                    nx_mfrr = low_val;
                    if (low_val < cur_cppr && low_val <= cur_ppri) begin
                        rej_raw = cur_xisr;
                        nx_ppri = low_val;
                        nx_xisr = IPI;
                    end
                    if (low_val > cur_mfrr) begin
                        resend = cur_nr;
                        nx_nr  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (down_en) begin
            nx_cppr = down_val;
            if (cur_mfrr < down_val && cur_mfrr <= cur_ppri) begin
                nx_ppri = cur_mfrr;
                nx_xisr = IPI;
            end
            resend = cur_nr;
            nx_nr  = 1'b0;
        end
    end

    assign rej_valid = (rej_raw != '0) && (rej_raw != IPI);
    assign rej_src   = rej_raw;
endmodule

// File: rtl/pres_dlv_unit.sv
module pres_dlv_unit #(
    parameter int PRI_W  = 8,
    parameter int SRC_W  = 24,
    parameter int IPI_ID = 2
) (
    input  logic             dlv_valid,
    input  logic [SRC_W-1:0] dlv_src,
    input  logic [PRI_W-1:0] dlv_pri,
    input  logic [PRI_W-1:0] in_cppr,
    input  logic [PRI_W-1:0] in_mfrr,
    input  logic [PRI_W-1:0] in_ppri,
    input  logic [SRC_W-1:0] in_xisr,
    input  logic             in_nr,
    output logic [PRI_W-1:0] nx_ppri,
    output logic [SRC_W-1:0] nx_xisr,
    output logic             nx_nr,
    output logic             ok,
    output logic             rej_valid,
    output logic [SRC_W-1:0] rej_src
);
    localparam logic [SRC_W-1:0] IPI = SRC_W'(IPI_ID);

    logic wins;
    assign wins = (dlv_pri < in_cppr) && (dlv_pri < in_mfrr) && (dlv_pri < in_ppri);
    assign ok   = dlv_valid && wins;

    always_comb begin
        nx_ppri = in_ppri;
        nx_xisr = in_xisr;
        nx_nr   = in_nr;
        if (ok) begin
            nx_ppri = dlv_pri;
            nx_xisr = dlv_src;
        end else if (dlv_valid) begin
            nx_nr = 1'b1;
        end
    end

    assign rej_src   = in_xisr;
    assign rej_valid = ok && (in_xisr != '0) && (in_xisr != IPI);
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import pres_pkg::*;
#(
    parameter int PRI_W  = 8,
    parameter int SRC_W  = 24,
    parameter int IPI_ID = 2,
    localparam int WORD_W = PRI_W + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlv_valid,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRI_W-1:0]  dlv_pri,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    output logic              irq_out,
    output logic              ret_valid,
    output logic [WORD_W-1:0] ret_word,
    output logic [PRI_W-1:0]  ret_mfrr,
    output logic              op_rej_valid,
    output logic [SRC_W-1:0]  op_rej_src,
    output logic              dlv_done,
    output logic              dlv_ok,
    output logic              dlv_rej_valid,
    output logic [SRC_W-1:0]  dlv_rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_req
);
    localparam logic [PRI_W-1:0] ONES = {PRI_W{1'b1}};
    localparam logic [SRC_W-1:0] IPI  = SRC_W'(IPI_ID);

    logic [PRI_W-1:0] cppr_q, mfrr_q, ppri_q;
    logic [SRC_W-1:0] xisr_q;
    logic             nr_q;

    logic [PRI_W-1:0] o_cppr, o_mfrr, o_ppri, d_ppri;
    logic [SRC_W-1:0] o_xisr, d_xisr, o_rej_src, o_eoi_src, d_rej_src;
    logic             o_nr, d_nr, o_ret_v, o_rej_v, o_eoi_v, o_resend, d_ok, d_rej_v;
    logic [WORD_W-1:0] o_ret_word;

    pres_op_unit #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_ID(IPI_ID)) u_op (
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .cur_cppr(cppr_q), .cur_mfrr(mfrr_q), .cur_ppri(ppri_q),
        .cur_xisr(xisr_q), .cur_nr(nr_q),
        .nx_cppr(o_cppr), .nx_mfrr(o_mfrr), .nx_ppri(o_ppri),
        .nx_xisr(o_xisr), .nx_nr(o_nr),
        .ret_valid(o_ret_v), .ret_word(o_ret_word),
        .rej_valid(o_rej_v), .rej_src(o_rej_src),
        .eoi_valid(o_eoi_v), .eoi_src(o_eoi_src), .resend(o_resend)
    );

    pres_dlv_unit #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_ID(IPI_ID)) u_dlv (
        .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_pri(dlv_pri),
        .in_cppr(o_cppr), .in_mfrr(o_mfrr), .in_ppri(o_ppri),
        .in_xisr(o_xisr), .in_nr(o_nr),
        .nx_ppri(d_ppri), .nx_xisr(d_xisr), .nx_nr(d_nr),
        .ok(d_ok), .rej_valid(d_rej_v), .rej_src(d_rej_src)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cppr_q        <= '0;
            mfrr_q        <= ONES;
            ppri_q        <= ONES;
            xisr_q        <= '0;
            nr_q          <= 1'b0;
            ret_valid     <= 1'b0;
            ret_word      <= '0;
            ret_mfrr      <= '0;
            op_rej_valid  <= 1'b0;
            op_rej_src    <= '0;
            dlv_done      <= 1'b0;
            dlv_ok        <= 1'b0;
            dlv_rej_valid <= 1'b0;
            dlv_rej_src   <= '0;
            eoi_valid     <= 1'b0;
            eoi_src       <= '0;
            resend_req    <= 1'b0;
        end else begin
            cppr_q        <= o_cppr;
            mfrr_q        <= o_mfrr;
            ppri_q        <= d_ppri;
            xisr_q        <= d_xisr;
            nr_q          <= d_nr;
            ret_valid     <= o_ret_v;
            ret_word      <= o_ret_word;
            ret_mfrr      <= mfrr_q;
            op_rej_valid  <= o_rej_v;
            op_rej_src    <= o_rej_src;
            dlv_done      <= dlv_valid;
            dlv_ok        <= d_ok;
            dlv_rej_valid <= d_rej_v;
            dlv_rej_src   <= d_rej_src;
            eoi_valid     <= o_eoi_v;
            eoi_src       <= o_eoi_src;
            resend_req    <= o_resend;
        end
    end

    assign irq_out = (xisr_q != '0) && (ppri_q < cppr_q);

    // R2: a taken delivery owns the pending slot afterwards
    p_dlv_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_ok |-> (ppri_q == $past(dlv_pri)) && (xisr_q == $past(dlv_src)));

    // R3: a refused delivery leaves the resend flag armed
    p_dlv_fail_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_done && !dlv_ok) |-> nr_q);

    // R4: accepting a pending source empties the slot
    p_accept_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'(OP_ACCEPT) && !dlv_valid && xisr_q != '0)
        |=> (xisr_q == '0) && (ppri_q == ONES));

    // R8: the reserved number is never forwarded as an EOI
    p_eoi_ipi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'(OP_EOI) && op_data[SRC_W-1:0] == IPI) |=> !eoi_valid);

    // R9: a poll without a delivery leaves the state unchanged
    p_poll_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'(OP_POLL) && !dlv_valid)
        |=> $stable(cppr_q) && $stable(mfrr_q) && $stable(ppri_q) && $stable(xisr_q) && $stable(nr_q));
endmodule

// File: tb/test_irq_presenter.sv
`timescale 1ns/1ps
module test_irq_presenter;
    localparam int PW = 4;
    localparam int SW = 8;
    localparam int IPI = 2;
    localparam int WW = PW + SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dlv_valid = 1'b0;
    logic [SW-1:0] dlv_src = '0;
    logic [PW-1:0] dlv_pri = '0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [WW-1:0] op_data = '0;
    logic irq_out, ret_valid, op_rej_valid, dlv_done, dlv_ok, dlv_rej_valid, eoi_valid, resend_req;
    logic [WW-1:0] ret_word;
    logic [PW-1:0] ret_mfrr;
    logic [SW-1:0] op_rej_src, dlv_rej_src, eoi_src;

    irq_presenter #(.PRI_W(PW), .SRC_W(SW), .IPI_ID(IPI)) i_irq_presenter (
        .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_pri(dlv_pri),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .irq_out(irq_out), .ret_valid(ret_valid), .ret_word(ret_word), .ret_mfrr(ret_mfrr),
        .op_rej_valid(op_rej_valid), .op_rej_src(op_rej_src),
        .dlv_done(dlv_done), .dlv_ok(dlv_ok), .dlv_rej_valid(dlv_rej_valid), .dlv_rej_src(dlv_rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // bench model state
    int m_cppr, m_mfrr, m_ppri, m_xisr, m_nr;
    // expected outputs
    int e_irq, e_ret_v, e_ret_word, e_ret_mfrr, e_orej_v, e_orej, e_done, e_ok, e_drej_v, e_drej;
    int e_eoi_v, e_eoi, e_resend;
    string t_ret, t_orej, t_res;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_down(input int nv);
        m_cppr = nv;
        if (m_mfrr < nv && m_mfrr <= m_ppri) begin
            m_ppri = m_mfrr;
            m_xisr = IPI;
        end
        e_resend = m_nr;
        m_nr = 0;
    endtask

    task automatic model_step(input int ov, input int code, input int data,
                              input int dv, input int src, input int pri);
        int rej = 0;
        int nv = data % 16;
        e_ret_v = 0; e_ret_word = m_cppr * 256 + m_xisr; e_ret_mfrr = m_mfrr;
        e_eoi_v = 0; e_eoi = data % 256; e_resend = 0;
        e_done = dv; e_ok = 0; e_drej_v = 0; e_drej = 0;
        t_ret = "R4"; t_orej = "R5"; t_res = "R6";
        if (ov != 0) begin
            case (code)
                0: begin
                    e_ret_v = 1;
                    if (m_xisr != 0) begin m_cppr = m_ppri; m_ppri = 15; m_xisr = 0; end
                end
                1: begin e_ret_v = 1; t_ret = "R9"; end
                2: begin
                    if (nv > m_cppr) model_down(nv);
                    else if (nv < m_cppr) begin
                        m_cppr = nv;
                        if (nv <= m_ppri) begin rej = m_xisr; m_xisr = 0; m_ppri = 15; end
                    end
                end
                3: begin
                    model_down(data / 256);
                    e_eoi_v = (e_eoi != IPI) ? 1 : 0;
                end
                4: begin
                    int old = m_mfrr;
                    t_orej = "R7"; t_res = "R7";
                    m_mfrr = nv;
                    if (nv < m_cppr && nv <= m_ppri) begin rej = m_xisr; m_ppri = nv; m_xisr = IPI; end
                    if (nv > old) begin e_resend = m_nr; m_nr = 0; end
                end
                default: ;
            endcase
        end
        e_orej = rej;
        e_orej_v = (rej != 0 && rej != IPI) ? 1 : 0;
        if (dv != 0) begin
            if (pri < m_cppr && pri < m_mfrr && pri < m_ppri) begin
                e_ok = 1; e_drej = m_xisr;
                e_drej_v = (m_xisr != 0 && m_xisr != IPI) ? 1 : 0;
                m_xisr = src; m_ppri = pri;
            end else m_nr = 1;
        end
        e_irq = (m_xisr != 0 && m_ppri < m_cppr) ? 1 : 0;
    endtask

    task automatic compare();
        chk("R1 irq_out", int'(irq_out), e_irq);
        chk("R11 ret_valid", int'(ret_valid), e_ret_v);
        if (e_ret_v != 0) chk({t_ret, " ret_word"}, int'(ret_word), e_ret_word);
        if (e_ret_v != 0 && t_ret == "R9") chk("R9 ret_mfrr", int'(ret_mfrr), e_ret_mfrr);
        chk({t_orej, "/R8 op_rej_valid"}, int'(op_rej_valid), e_orej_v);
        if (e_orej_v != 0) chk({t_orej, " op_rej_src"}, int'(op_rej_src), e_orej);
        chk("R2 dlv_done", int'(dlv_done), e_done);
        if (e_done != 0) chk(e_ok != 0 ? "R2 dlv_ok" : "R3 dlv_ok", int'(dlv_ok), e_ok);
        chk("R2/R8 dlv_rej_valid", int'(dlv_rej_valid), e_drej_v);
        if (e_drej_v != 0) chk("R2 dlv_rej_src", int'(dlv_rej_src), e_drej);
        chk("R8 eoi_valid", int'(eoi_valid), e_eoi_v);
        if (e_eoi_v != 0) chk("R8 eoi_src", int'(eoi_src), e_eoi);
        chk({t_res, "/R3 resend_req"}, int'(resend_req), e_resend);
    endtask

    task automatic cycle(input int ov, input int code, input int data,
                         input int dv, input int src, input int pri);
        op_valid = ov[0]; op_code = code[2:0]; op_data = data[WW-1:0];
        dlv_valid = dv[0]; dlv_src = src[SW-1:0]; dlv_pri = pri[PW-1:0];
        model_step(ov, code, data, dv, src, pri);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired before the run ended");
            summary();
            $finish;
        end
    end

    initial begin
        m_cppr = 0; m_mfrr = 15; m_ppri = 15; m_xisr = 0; m_nr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state visible at the ports
        chk("R10 irq_out", int'(irq_out), 0);
        chk("R10 ret_valid", int'(ret_valid), 0);
        chk("R10 resend_req", int'(resend_req), 0);
        cycle(1, 1, 0, 0, 0, 0);
        chk("R10 poll word", int'(ret_word), 0);
        chk("R10 poll mfrr", int'(ret_mfrr), 15);
        cycle(0, 0, 0, 1, 9, 0);
        chk("R10 delivery refused", int'(dlv_ok), 0);
        // R5: equal priority write has no effect
        cycle(1, 2, 9, 0, 0, 0);
        cycle(1, 4, 15, 0, 0, 0);
        chk("R3 resend after refusal", int'(resend_req), 0);
        cycle(0, 0, 0, 1, 7, 4);
        chk("R2 taken", int'(dlv_ok), 1);
        cycle(1, 2, 9, 0, 0, 0);
        chk("R5 equal write no reject", int'(op_rej_valid), 0);
        cycle(1, 1, 0, 0, 0, 0);
        chk("R5 equal write state", int'(ret_word), 9 * 256 + 7);
        // R8: EOI of the reserved number is not forwarded
        cycle(1, 3, 15 * 256 + IPI, 0, 0, 0);
        chk("R8 eoi reserved", int'(eoi_valid), 0);
        // R11: op codes 5..7 are ignored
        cycle(1, 5, 3, 0, 0, 0);
        cycle(1, 1, 0, 0, 0, 0);
        chk("R11 unused code", int'(ret_word), m_cppr * 256 + m_xisr);
        // near-exhaustive pseudo-random sweep
        for (int n = 0; n < 20000; n++) begin
            int ov, code, data, dv, src, pri, sel;
            seed = nxt(seed);
            ov = (seed[19:16] < 4'd10) ? 1 : 0;
            code = int'(seed[23:20]) % 5;
            sel = int'(seed[26:24]);
            src = (sel == 0) ? IPI : 3 + int'(seed[31:27]) % 20;
            if (sel == 1) src = m_xisr;
            seed = nxt(seed);
            data = (code == 3) ? int'(seed[19:16]) * 256 + src : int'(seed[19:16]);
            dv = (seed[23:21] < 3'd4) ? 1 : 0;
            pri = int'(seed[27:24]);
            cycle(ov, code, data, dv, 3 + int'(seed[31:28]), pri);
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule